// File: doc/BRIEF.md
# Post-Event Conversion Stop Gate

This block sits in the path of the conversion trigger pulses that start an analog-to-digital converter. When the mode is enabled, every trigger reaches the converter, so samples are taken continuously. Software drains the samples from the sample buffer while it waits. An external event input marks the moment of interest. After the event, the block counts the triggers it lets through. When exactly N of them have passed, it closes the gate for good, so the last N samples in the buffer follow the event.

Software writes the post-event count N while the mode is off and then turns the mode on. It polls the live countdown value, or the done flag, to learn when acquisition has stopped. The event input is asynchronous to the block clock. It is brought into the clock domain through a synchronizer chain, and only its rising edge is used. Turning the mode off returns the block to a clean state for the next run.

Top module: `acq_stop_gate`

## Requirements
- R1: While reset is asserted, `done` is 0 and `cnt_live` is 0.
- R2: While `mode_en` is 0, `trig_out` stays 0 whatever `trig_in` does. Each clock edge with `mode_en` at 0 loads `cnt_live` from `post_cnt`, so it shows the loaded value from the next cycle on.
- R3: While `mode_en` is 1 and no event has armed the block, each `trig_in` pulse appears on `trig_out` in the same cycle, and `cnt_live` keeps its value.
- R4: The first rising edge of `ext_evt` after enabling arms the block. A `trig_in` pulse present at the third rising clock edge after `ext_evt` is first sampled high, or at any later edge, is counted. Each counted pulse passes through and lowers `cnt_live` by one at that edge.
- R5: The counted pulse that takes `cnt_live` from 1 to 0 still passes through and sets `done` at the same edge. From then on, `trig_out` stays 0.
- R6: A `post_cnt` of 0 is loaded as 1, so one post-event conversion is still taken.
- R7: Once the block is armed or done, further `ext_evt` edges have no effect. The count is neither reloaded nor restarted, and a closed gate stays closed.
- R8: A clock edge with `mode_en` at 0 clears `done`, leaves the block unarmed and reloads `cnt_live`. A later enable starts a fresh run.
- R9: `done` stays 1 for as long as `mode_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Mode enable written by software |
| post_cnt | input | 16 | Number N of post-event conversions |
| ext_evt | input | 1 | Asynchronous external event |
| trig_in | input | 1 | Raw conversion trigger, one cycle per pulse |
| trig_out | output | 1 | Gated conversion trigger |
| cnt_live | output | 16 | Live countdown value for polling |
| done | output | 1 | Sticky flag: acquisition has stopped |

## Verification
`trig_out` is a combinational function of `trig_in`, so it is sampled one time step after the bench drives the pulse on the falling edge, before the next rising edge. `cnt_live` and `done` change at the rising edge that consumes a pulse or a mode change. They are read at the following falling edge. An event needs three rising edges to arm the block (two synchronizer stages and the edge detector). The bench holds `ext_evt` high for three cycles before it sends any pulse that should be counted, and it counts each expected decrement from the loaded N.

// File: rtl/acq_stop_pkg.sv
package acq_stop_pkg;

  typedef enum logic [1:0] {
    GS_OFF   = 2'd0,
    GS_FREE  = 2'd1,
    GS_ARMED = 2'd2,
    GS_DONE  = 2'd3
  } gate_state_t;

  // Load value for a run: a zero request is raised to one.
  function automatic logic [15:0] load_value(input logic [15:0] req);
    return (req == 16'd0) ? 16'd1 : req;
  endfunction

  // One counted conversion: step down, never below zero.
  function automatic logic [15:0] step_down(input logic [15:0] cur);
    return (cur == 16'd0) ? 16'd0 : cur - 16'd1;
  endfunction

  // True when a counted conversion finishes the run.
  function automatic logic is_last(input logic [15:0] cur);
    return cur == 16'd1;
  endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int TOTAL = STAGES + 1;

  logic [TOTAL-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_in;
      for (int i = 1; i < TOTAL; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign rise_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
  import acq_stop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_en,
  input  logic        evt_rise,
  input  logic        counted,
  input  logic        last_hit,
  output gate_state_t state,
  output logic        gate_open,
  output logic        armed
);
  gate_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!mode_en) begin
      state_d = GS_OFF;
    end else begin
      unique case (state_q)
        GS_OFF:   state_d = evt_rise ? GS_ARMED : GS_FREE;
        GS_FREE:  if (evt_rise) state_d = GS_ARMED;
        GS_ARMED: if (counted && last_hit) state_d = GS_DONE;
        GS_DONE:  state_d = GS_DONE;
        default:  state_d = GS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GS_OFF;
    else        state_q <= state_d;
  end

  assign state     = state_q;
  assign gate_open = mode_en && (state_q != GS_DONE);
  assign armed     = (state_q == GS_ARMED);
endmodule

// File: rtl/post_counter.sv
module post_counter
  import acq_stop_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [CNT_W-1:0] req_cnt,
  input  logic             counted,
  output logic [CNT_W-1:0] cnt,
  output logic             last_hit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (reload)  cnt_q <= load_value(req_cnt);
    else if (counted) cnt_q <= step_down(cnt_q);
  end

  assign cnt      = cnt_q;
  assign last_hit = is_last(cnt_q);
endmodule

// File: rtl/acq_stop_gate.sv
module acq_stop_gate
  import acq_stop_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_en,
  input  logic [CNT_W-1:0] post_cnt,
  input  logic             ext_evt,
  input  logic             trig_in,
  output logic             trig_out,
  output logic [CNT_W-1:0] cnt_live,
  output logic             done
);
  gate_state_t state;
  logic        evt_rise;
  logic        gate_open;
  logic        armed;
  logic        counted;
  logic        last_hit;
  logic        reload;

  evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (ext_evt),
    .rise_pulse (evt_rise)
  );

  gate_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_en   (mode_en),
    .evt_rise  (evt_rise),
    .counted   (counted),
    .last_hit  (last_hit),
    .state     (state),
    .gate_open (gate_open),
    .armed     (armed)
  );

  assign reload   = !mode_en || (state == GS_OFF);
  assign trig_out = trig_in && gate_open;
  assign counted  = trig_out && armed;

  post_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (reload),
    .req_cnt  (post_cnt),
    .counted  (counted),
    .cnt      (cnt_live),
    .last_hit (last_hit)
  );

  assign done = (state == GS_DONE);
endmodule

// File: rtl/acq_stop_gate_chk.sv
module acq_stop_gate_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_en,
  input logic [CNT_W-1:0] post_cnt,
  input logic             trig_out,
  input logic [CNT_W-1:0] cnt_live,
  input logic             done,
  input logic             armed,
  input logic             evt_rise
);
  AST_OFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> !trig_out); // R2
  AST_OFF_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_en && post_cnt != '0) |=> cnt_live == $past(post_cnt)); // R2
  AST_FREE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_en) && mode_en && !armed && !done) |=> $stable(cnt_live)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && armed && trig_out) |=> cnt_live == $past(cnt_live) - 1'b1); // R4
  AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !trig_out); // R5
  AST_ZERO_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_en && post_cnt == '0) |=> cnt_live == 1); // R6
  AST_LATE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && armed && evt_rise && !trig_out) |=> $stable(cnt_live)); // R7
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !done); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_en) |=> done); // R9
endmodule

bind acq_stop_gate acq_stop_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_en  (mode_en),
  .post_cnt (post_cnt),
  .trig_out (trig_out),
  .cnt_live (cnt_live),
  .done     (done),
  .armed    (armed),
  .evt_rise (evt_rise)
);

// File: tb/acq_stop_gate_tb_top.sv
module acq_stop_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_en = 1'b0;
  logic [15:0] post_cnt = 16'd0;
  logic        ext_evt = 1'b0;
  logic        trig_in = 1'b0;
  logic        trig_out;
  logic [15:0] cnt_live;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acq_stop_gate dut_i (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .post_cnt(post_cnt),
    .ext_evt(ext_evt), .trig_in(trig_in), .trig_out(trig_out),
    .cnt_live(cnt_live), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One trigger pulse across one rising edge; returns whether it passed.
  task automatic pulse(output logic passed);
    @(negedge clk);
    trig_in = 1'b1;
    #1 passed = trig_out;
    @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic fire_event();
    @(negedge clk);
    ext_evt = 1'b1;
    repeat (3) @(negedge clk);
    ext_evt = 1'b0;
  endtask

  task automatic set_mode(input logic en);
    @(negedge clk);
    mode_en = en;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    #2;
    chk("R1 done in reset", done, 0);
    chk("R1 count in reset", cnt_live, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_off();
    logic p;
    post_cnt = 16'd5;
    repeat (2) @(negedge clk);
    pulse(p);
    chk("R2 blocked while off", p, 0);
    chk("R2 count loaded", cnt_live, 5);
  endtask

  task automatic t_free();
    logic p;
    set_mode(1'b1);
    for (int i = 0; i < 4; i++) begin
      pulse(p);
      chk("R3 free trigger passes", p, 1);
      chk("R3 count held", cnt_live, 5);
    end
  endtask

  task automatic t_run();
    logic p;
    fire_event();
    for (int i = 1; i <= 5; i++) begin
      pulse(p);
      chk("R4 counted trigger passes", p, 1);
      chk("R4 count steps", cnt_live, 32'(5 - i));
      chk("R5 done timing", done, (i == 5) ? 1 : 0);
    end
    pulse(p);
    chk("R5 blocked after done", p, 0);
    repeat (4) @(negedge clk);
    chk("R9 done sticky", done, 1);
    fire_event();
    pulse(p);
    chk("R7 event after done ignored", p, 0);
    chk("R7 count stays zero", cnt_live, 0);
  endtask

  task automatic t_rearm();
    post_cnt = 16'd3;
    set_mode(1'b0);
    chk("R8 done cleared", done, 0);
    chk("R8 count reloaded", cnt_live, 3);
  endtask

  task automatic t_second_edge();
    logic p;
    set_mode(1'b1);
    fire_event();
    pulse(p);
    chk("R4 first counted", cnt_live, 2);
    fire_event();
    chk("R7 second edge no reload", cnt_live, 2);
    pulse(p);
    chk("R7 keeps counting", cnt_live, 1);
    pulse(p);
    chk("R5 last passes", p, 1);
    chk("R5 done set", done, 1);
  endtask

  task automatic t_zero();
    logic p;
    post_cnt = 16'd0;
    set_mode(1'b0);
    chk("R6 zero loads as one", cnt_live, 1);
    set_mode(1'b1);
    fire_event();
    pulse(p);
    chk("R6 one conversion passes", p, 1);
    chk("R6 done after one", done, 1);
    pulse(p);
    chk("R6 then blocked", p, 0);
  endtask

  initial begin
    t_reset();
    t_off();
    t_free();
    t_run();
    t_rearm();
    t_second_edge();
    t_zero();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule